// File: doc/BRIEF.md
# Linear Buffer Blit Splitter

This block accepts one request to fill or copy a contiguous run of bytes and turns it into a series of rectangle descriptors. A downstream 2D blit engine can accept each of these descriptors. The engine limits a scan line to 32768 bytes and a rectangle to 65536 lines. A long run is therefore folded into rectangles. Each rectangle has a fixed dword-aligned pitch of 32764, which sits just below the signed 16-bit limit. A final short remainder goes out as a single line with zero pitch.

A request carries a destination offset, a source offset (used by copies only), a byte count, a pixel-size code and a fill value. Both the request side and the descriptor side use a valid/ready handshake. The block accepts one request at a time. It reports the end of a request with a one-cycle done pulse. A fill whose offset or size does not match its pixel size produces a one-cycle reject pulse instead, and no descriptor is emitted.

Top module: `lbs_splitter`

## Requirements
- R1: A fill request (req_copy_i=0) is rejected when its destination offset or its size is not a multiple of the pixel size. The pixel size is 1 byte for code 0, 2 bytes for code 1, and 4 bytes for codes 2 and 3. A rejection raises reject_o for one cycle, in the cycle after acceptance, and no descriptor is emitted.
- R2: When the remaining size is at most 32768, the block emits one descriptor with width equal to the remaining size, height 1 and pitch 0.
- R3: When the remaining size exceeds 32768, the descriptor has pitch 32764 and width 32764. Its height is the remaining size divided by 32764 (rounded down), capped at 65536.
- R4: After each accepted descriptor, the offsets advance by pitch times height and the remaining size drops by width times height. Descriptors continue until no size remains. desc_last_o marks the final descriptor.
- R5: A fill uses raster operation 0xF0, format code equal to the pixel-size code (code 3 maps to 2), carries the fill value, and drives the source offset output as 0. A copy uses raster operation 0xCC with format code 0, ignores the pixel-size code, and is never rejected.
- R6: In a copy, the source and destination offsets share the same pitch and advance by the same amount after every descriptor.
- R7: A request of size zero that is not rejected raises done_o in the cycle after acceptance and emits no descriptor.
- R8: While desc_valid_o is high and desc_ready_i is low, desc_valid_o and every descriptor field stay unchanged.
- R9: req_ready_o is low while a request's descriptors are pending. done_o pulses for one cycle in the cycle after the final descriptor handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_copy_i | input | 1 | 1 = copy, 0 = fill |
| req_dst_off_i | input | 32 | Destination byte offset |
| req_src_off_i | input | 32 | Source byte offset (copy only) |
| req_size_i | input | 32 | Byte count |
| req_bpp_i | input | 2 | Pixel-size code (fill only) |
| req_fill_i | input | 32 | Fill value |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor accepted |
| desc_width_o | output | 16 | Bytes per line |
| desc_height_o | output | 17 | Line count |
| desc_pitch_o | output | 16 | Line pitch in bytes |
| desc_dst_off_o | output | 32 | Destination offset |
| desc_src_off_o | output | 32 | Source offset |
| desc_rop_o | output | 8 | Raster operation |
| desc_fmt_o | output | 2 | Format code |
| desc_fill_o | output | 32 | Fill value |
| desc_last_o | output | 1 | Final descriptor of the request |
| done_o | output | 1 | Request finished pulse |
| reject_o | output | 1 | Request rejected pulse |

## Verification
A stale remaining-size or offset register shows up on the next descriptor after a handshake. The offset is off by a whole rectangle, or a descriptor is repeated, or desc_last_o appears on the wrong beat. A wrong height cap or pitch choice corrupts the very first descriptor of a long run. The directed cases therefore exercise the exact 32768 boundary, one byte past it, and a run large enough to hit the 65536-line cap. A state machine stuck in the busy state shows as req_ready_o held low and done_o missing within one cycle of the final handshake.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam logic [7:0] ROP_FILL = 8'hF0;
  localparam logic [7:0] ROP_COPY = 8'hCC;
  localparam logic [1:0] FMT_8    = 2'd0;
  localparam logic [1:0] FMT_32   = 2'd2;

  typedef enum logic {ST_IDLE, ST_EMIT} state_e;
endpackage

// File: rtl/lbs_chunker.sv
module lbs_chunker #(
  parameter int AW        = 32,
  parameter int LINE_MAX  = 32768,
  parameter int PITCH     = 32764,
  parameter int LINES_MAX = 65536,
  localparam int WW = $clog2(LINE_MAX + 1),
  localparam int HW = $clog2(LINES_MAX + 1)
) (
  input  logic [AW-1:0] rem_i,
  output logic [WW-1:0] width_o,
  output logic [HW-1:0] height_o,
  output logic [WW-1:0] pitch_o,
  output logic [AW-1:0] step_o,
  output logic [AW-1:0] used_o
);
  logic [AW-1:0] lines_raw, lines;

  assign lines_raw = rem_i / AW'(PITCH);
  assign lines     = (lines_raw > AW'(LINES_MAX)) ? AW'(LINES_MAX) : lines_raw;

  always_comb begin
    if (rem_i <= AW'(LINE_MAX)) begin
      width_o  = WW'(rem_i);
      height_o = HW'(1);
      pitch_o  = '0;
      step_o   = '0;
      used_o   = rem_i;
    end else begin
      width_o  = WW'(PITCH);
      height_o = HW'(lines);
      pitch_o  = WW'(PITCH);
      step_o   = lines * AW'(PITCH);
      used_o   = lines * AW'(PITCH);
    end
  end
endmodule

// File: rtl/lbs_check.sv
module lbs_check #(
  parameter int AW = 32
) (
  input  logic          copy_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] size_i,
  input  logic [1:0]    bpp_i,
  output logic          bad_o
);
  logic [AW-1:0] mask;

  always_comb begin
    case (bpp_i)
      2'd0:    mask = AW'(0);
      2'd1:    mask = AW'(1);
      default: mask = AW'(3);
    endcase
  end

  assign bad_o = !copy_i && (((off_i | size_i) & mask) != '0);
endmodule

// File: rtl/lbs_splitter.sv
module lbs_splitter
  import lbs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_MAX  = 32768,
  parameter int PITCH     = 32764,
  parameter int LINES_MAX = 65536,
  localparam int WW = $clog2(LINE_MAX + 1),
  localparam int HW = $clog2(LINES_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_copy_i,
  input  logic [AW-1:0] req_dst_off_i,
  input  logic [AW-1:0] req_src_off_i,
  input  logic [AW-1:0] req_size_i,
  input  logic [1:0]    req_bpp_i,
  input  logic [31:0]   req_fill_i,
  output logic          desc_valid_o,
  input  logic          desc_ready_i,
  output logic [WW-1:0] desc_width_o,
  output logic [HW-1:0] desc_height_o,
  output logic [WW-1:0] desc_pitch_o,
  output logic [AW-1:0] desc_dst_off_o,
  output logic [AW-1:0] desc_src_off_o,
  output logic [7:0]    desc_rop_o,
  output logic [1:0]    desc_fmt_o,
  output logic [31:0]   desc_fill_o,
  output logic          desc_last_o,
  output logic          done_o,
  output logic          reject_o
);
  state_e        state_q;
  logic [AW-1:0] rem_q, dst_q, src_q;
  logic          copy_q, done_q, reject_q;
  logic [1:0]    fmt_q;
  logic [31:0]   fill_q;

  logic [AW-1:0] step, used;
  logic          bad, fire, last;

  lbs_check #(.AW(AW)) u_check (
    .copy_i (req_copy_i),
    .off_i  (req_dst_off_i),
    .size_i (req_size_i),
    .bpp_i  (req_bpp_i),
    .bad_o  (bad)
  );

  lbs_chunker #(.AW(AW), .LINE_MAX(LINE_MAX), .PITCH(PITCH), .LINES_MAX(LINES_MAX)) u_chunk (
    .rem_i    (rem_q),
    .width_o  (desc_width_o),
    .height_o (desc_height_o),
    .pitch_o  (desc_pitch_o),
    .step_o   (step),
    .used_o   (used)
  );

  assign req_ready_o    = (state_q == ST_IDLE);
  assign desc_valid_o   = (state_q == ST_EMIT);
  assign desc_dst_off_o = dst_q;
  assign desc_src_off_o = copy_q ? src_q : '0;
  assign desc_rop_o     = copy_q ? ROP_COPY : ROP_FILL;
  assign desc_fmt_o     = fmt_q;
  assign desc_fill_o    = fill_q;
  assign last           = (used == rem_q);
  assign desc_last_o    = last;
  assign fire           = desc_valid_o && desc_ready_i;
  assign done_o         = done_q;
  assign reject_o       = reject_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rem_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      copy_q   <= 1'b0;
      fmt_q    <= FMT_8;
      fill_q   <= '0;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (bad) begin
            reject_q <= 1'b1;
          end else if (req_size_i == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_EMIT;
            rem_q   <= req_size_i;
            dst_q   <= req_dst_off_i;
            src_q   <= req_src_off_i;
            copy_q  <= req_copy_i;
            fill_q  <= req_fill_i;
            if (req_copy_i)              fmt_q <= FMT_8;
            else if (req_bpp_i == 2'd3)  fmt_q <= FMT_32;
            else                         fmt_q <= req_bpp_i;
          end
        end
        ST_EMIT: if (fire) begin
          rem_q <= rem_q - used;
          dst_q <= dst_q + step;
          src_q <= src_q + step;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_width_o) &&
      $stable(desc_height_o) && $stable(desc_pitch_o) && $stable(desc_dst_off_o) &&
      $stable(desc_src_off_o) && $stable(desc_last_o));

  p_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (desc_pitch_o == '0 && desc_height_o == HW'(1) && desc_width_o != '0) ||
      (desc_pitch_o == WW'(PITCH) && desc_width_o == WW'(PITCH) &&
       desc_height_o != '0 && desc_height_o <= HW'(LINES_MAX)));

  p_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && !desc_last_o |=> desc_valid_o &&
      desc_dst_off_o == $past(desc_dst_off_o) + AW'($past(desc_pitch_o)) * AW'($past(desc_height_o)));

  p_lockstep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_ready_i && !desc_last_o && desc_rop_o == ROP_COPY |=>
      (desc_dst_off_o - desc_src_off_o) == $past(desc_dst_off_o - desc_src_off_o));

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> !req_ready_o);

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !desc_valid_o && !done_o);

  p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_size_i == '0 && req_copy_i |=> done_o && !desc_valid_o);
endmodule

// File: tb/tb_lbs_splitter.sv
module tb_lbs_splitter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_copy = 0;
  logic [31:0] req_dst = 0, req_src = 0, req_size = 0, req_fill = 0;
  logic [1:0]  req_bpp = 0;
  logic        desc_ready = 0;
  logic        req_ready, desc_valid, desc_last, done, reject;
  logic [15:0] d_width, d_pitch;
  logic [16:0] d_height;
  logic [31:0] d_dst, d_src, d_fill;
  logic [7:0]  d_rop;
  logic [1:0]  d_fmt;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lbs_splitter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_copy_i(req_copy),
    .req_dst_off_i(req_dst), .req_src_off_i(req_src), .req_size_i(req_size),
    .req_bpp_i(req_bpp), .req_fill_i(req_fill),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_width_o(d_width), .desc_height_o(d_height), .desc_pitch_o(d_pitch),
    .desc_dst_off_o(d_dst), .desc_src_off_o(d_src), .desc_rop_o(d_rop),
    .desc_fmt_o(d_fmt), .desc_fill_o(d_fill), .desc_last_o(desc_last),
    .done_o(done), .reject_o(reject)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_req(bit copy, int unsigned dst, int unsigned src, int unsigned size,
                        logic [1:0] bpp, logic [31:0] fill, int stall);
    longint unsigned rem, od, os, w, h, p;
    int unsigned mask;
    bit rej;
    mask = (bpp == 0) ? 0 : (bpp == 1) ? 1 : 3;
    rej  = !copy && (((dst | size) & mask) != 0);
    @(negedge clk);
    req_valid = 1; req_copy = copy; req_dst = dst; req_src = src;
    req_size = size; req_bpp = bpp; req_fill = fill;
    chk(req_ready == 1, "R9", "ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (rej) begin
      chk(reject == 1, "R1", "reject pulse", reject, 1);
      chk(desc_valid == 0, "R1", "no descriptor", desc_valid, 0);
      @(negedge clk);
      chk(desc_valid == 0 && reject == 0, "R1", "stays idle", desc_valid, 0);
      return;
    end
    chk(reject == 0, "R5", "no reject", reject, 0);
    if (size == 0) begin
      chk(done == 1, "R7", "zero done", done, 1);
      chk(desc_valid == 0, "R7", "zero no desc", desc_valid, 0);
      return;
    end
    rem = size; od = dst; os = src;
    while (rem > 0) begin
      if (rem <= 32768) begin w = rem; h = 1; p = 0; end
      else begin
        w = 32764; p = 32764; h = rem / 32764;
        if (h > 65536) h = 65536;
      end
      chk(desc_valid == 1, "R4", "desc valid", desc_valid, 1);
      chk(req_ready == 0, "R9", "busy", req_ready, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(desc_valid == 1 && d_width == w && d_dst == od[31:0], "R8", "held", d_width, w);
      end
      desc_ready = 1;
      chk(d_width == w, (p == 0) ? "R2" : "R3", "width", d_width, w);
      chk(d_height == h, (p == 0) ? "R2" : "R3", "height", d_height, h);
      chk(d_pitch == p, (p == 0) ? "R2" : "R3", "pitch", d_pitch, p);
      chk(d_dst == od[31:0], "R4", "dst off", d_dst, od[31:0]);
      chk(d_src == (copy ? os[31:0] : 32'd0), "R6", "src off", d_src, copy ? os[31:0] : 0);
      chk(d_rop == (copy ? 8'hCC : 8'hF0), "R5", "rop", d_rop, copy ? 8'hCC : 8'hF0);
      chk(d_fmt == (copy ? 2'd0 : (bpp == 3 ? 2'd2 : bpp)), "R5", "fmt", d_fmt,
          copy ? 0 : (bpp == 3 ? 2 : bpp));
      if (!copy) chk(d_fill == fill, "R5", "fill", d_fill, fill);
      chk(desc_last == (w * h == rem), "R4", "last flag", desc_last, w * h == rem);
      @(posedge clk);
      @(negedge clk);
      desc_ready = 0;
      rem = rem - w * h;
      od = od + p * h;
      os = os + p * h;
    end
    chk(done == 1, "R9", "done after last", done, 1);
    chk(desc_valid == 0, "R9", "idle after last", desc_valid, 0);
    @(negedge clk);
    chk(done == 0, "R9", "done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && desc_valid == 0, "R9", "reset idle", desc_valid, 0);
    chk(done == 0 && reject == 0, "R7", "reset pulses", done, 0);
  endtask

  task automatic t_fill_small();  do_req(0, 16, 0, 100, 2'd2, 32'hDEADBEEF, 0); endtask
  task automatic t_fill_edge();   do_req(0, 3, 0, 32768, 2'd0, 32'h11, 0); endtask
  task automatic t_fill_over();   do_req(0, 8, 0, 32769, 2'd0, 32'h22, 1); endtask
  task automatic t_fill_bpp3();   do_req(0, 64, 0, 40000, 2'd3, 32'h12345678, 0); endtask
  task automatic t_copy_multi();  do_req(1, 1000, 5003, 3 * 32764 + 10, 2'd3, 0, 3); endtask
  task automatic t_copy_cap();    do_req(1, 32'h100, 32'h40, 32764 * 65536 + 100, 2'd1, 0, 0); endtask
  task automatic t_reject();
    do_req(0, 0, 0, 7, 2'd1, 0, 0);
    do_req(0, 2, 0, 8, 2'd2, 0, 0);
    do_req(0, 1, 0, 6, 2'd1, 0, 0);
  endtask
  task automatic t_zero();
    do_req(0, 0, 0, 0, 2'd0, 0, 0);
    do_req(1, 5, 9, 0, 2'd0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_small();
    t_fill_edge();
    t_fill_over();
    t_fill_bpp3();
    t_copy_multi();
    t_copy_cap();
    t_reject();
    t_zero();
    t_fill_small();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule